// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a processor core and decides when the running code must be interrupted. It watches a parameterised set of external request lines plus one non-maskable input, latches a pending flag on each rising edge, and picks the most urgent enabled request. That candidate is offered to the core only when it outranks the exception already running and no mask blocks it. The offer carries an exception number and the address of that number's entry in a table of handler addresses.

The core answers with a one-cycle acknowledge when it starts the handler and a one-cycle completion pulse when the handler returns. On acknowledge the controller pushes the handler's priority onto an internal stack of nested activity. On completion it pops that entry, so the running priority falls back to the interrupted handler, or to thread level when the stack is empty. Software programs the enables, the per-line priorities, a priority threshold and a global mask through a simple write port.

Top module: `irqc_top`

## Requirements
- R1: A line's pending flag is set by a 0-to-1 transition of that line and stays set until the core acknowledges that line. Holding a line high after its acknowledge does not set the flag again.
- R2: Among lines that are pending, enabled and not active, the one with the numerically smallest 8-bit priority wins. Equal priorities go to the lower line index. The offered number for line k is 16 + k.
- R3: The offered vector equals VEC_BASE + 4 × the offered number.
- R4: A maskable request is offered only when its priority is strictly more urgent than the running priority. An equal priority never preempts.
- R5: A nonzero threshold (write address 0x001) suppresses every line whose priority value is greater than or equal to the threshold. A threshold of zero suppresses nothing.
- R6: While the global mask bit (write address 0x000, data bit 0) is 1, no maskable line is offered.
- R7: The non-maskable input latches on a rising edge and is offered as number 2, regardless of masks, threshold or nesting depth. It is not offered again while its own handler is running.
- R8: An acknowledge while an offer is valid (and no completion pulse is present) pushes the offered priority and clears that pending flag. A completion pulse pops one level, restoring the preempted priority, or thread level when nothing remains.
- R9: A line whose handler is active is never offered, even after its priority has been rewritten to a more urgent value. It becomes eligible once its handler completes.
- R10: At most STACK_DEPTH maskable handlers nest; when that many are active no maskable line is offered, although the non-maskable input still is.
- R11: A disabled line still latches its pending flag but is not offered. Enabling it (address 0x100 + k, data bit 0) while it is pending makes it eligible. Priority of line k is written at 0x200 + k, data bits 7:0.
- R12: After reset every line is disabled with priority 0, threshold and global mask are 0, nothing is pending or active, and no offer is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_IRQ | External request lines, edge-detected |
| nmi | input | 1 | Non-maskable request, edge-detected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register address: bits 9:8 select a bank, 7:0 the line or control field |
| wr_data | input | 32 | Register write data |
| ack | input | 1 | Core has entered the offered handler |
| done | input | 1 | Core has returned from the innermost handler |
| req_valid | output | 1 | A preemption is being requested |
| req_num | output | 8 | Exception number of the request |
| req_vec | output | 32 | Handler table entry address for the request |

## Verification
The bench pushes on the places where a comparison can be off by one: a priority exactly equal to the running one, or exactly equal to the threshold. A design using a non-strict compare would preempt an equal handler or let the threshold value through. It rewrites the priority of a running line to a more urgent value and re-raises it, which catches a controller that tracks activity by priority alone and so lets a handler preempt itself. It also fills the nesting stack, showing that maskable lines stall while the non-maskable input still lands, and checks that each completion restores exactly the previous level rather than jumping to thread level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int PRIO_W = 8;
    localparam int NUM_W  = 8;
    localparam int RANK_W = PRIO_W + 1;
    localparam int ADDR_W = 10;

    // rank 0 is the non-maskable level, all ones is thread level
    localparam logic [RANK_W-1:0] NMI_RANK    = '0;
    localparam logic [RANK_W-1:0] THREAD_RANK = '1;
    localparam logic [NUM_W-1:0]  NMI_NUM     = 8'd2;
    localparam logic [NUM_W-1:0]  EXT_BASE    = 8'd16;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_EN   = 2'b01,
        SEL_PRIO = 2'b10,
        SEL_NONE = 2'b11
    } wsel_e;

    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [NUM_W-1:0]  num;
        logic              is_nmi;
    } frame_t;

    typedef struct packed {
        logic              found;
        logic [NUM_W-1:0]  line;
        logic [PRIO_W-1:0] prio;
    } pick_t;

    function automatic logic [RANK_W-1:0] prio_rank(input logic [PRIO_W-1:0] p);
        return {1'b0, p} + RANK_W'(1);
    endfunction

    function automatic logic [31:0] vec_addr(input logic [31:0] base,
                                             input logic [NUM_W-1:0] num);
        return base + {22'b0, num, 2'b00};
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [31:0]                      wr_data,
    output logic [NUM_IRQ-1:0]               en_o,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio_o,
    output logic [PRIO_W-1:0]                thr_o,
    output logic                             gmask_o
);

    wsel_e sel;
    assign sel = wsel_e'(wr_addr[ADDR_W-1:ADDR_W-2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o    <= '0;
            prio_o  <= '0;
            thr_o   <= '0;
            gmask_o <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    if (wr_addr[0]) thr_o   <= wr_data[PRIO_W-1:0];
                    else            gmask_o <= wr_data[0];
                end
                SEL_EN: begin
                    for (int k = 0; k < NUM_IRQ; k++)
                        if (wr_addr[7:0] == NUM_W'(k)) en_o[k] <= wr_data[0];
                end
                SEL_PRIO: begin
                    for (int k = 0; k < NUM_IRQ; k++)
                        if (wr_addr[7:0] == NUM_W'(k)) prio_o[k] <= wr_data[PRIO_W-1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] lines,
    input  logic               nmi_in,
    input  logic [NUM_IRQ-1:0] ack_hot,
    input  logic               ack_nmi,
    input  logic [NUM_IRQ-1:0] done_hot,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic [NUM_IRQ-1:0] active_o,
    output logic               nmi_pend_o
);

    logic [NUM_IRQ-1:0] lines_q;
    logic               nmi_q;
    logic [NUM_IRQ-1:0] rise;
    logic               nmi_rise;

    assign rise     = lines & ~lines_q;
    assign nmi_rise = nmi_in & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q    <= '0;
            nmi_q      <= 1'b0;
            pend_o     <= '0;
            active_o   <= '0;
            nmi_pend_o <= 1'b0;
        end else begin
            lines_q    <= lines;
            nmi_q      <= nmi_in;
            // a fresh edge in the acknowledge cycle is a new request
            pend_o     <= (pend_o & ~ack_hot) | rise;
            active_o   <= (active_o | ack_hot) & ~done_hot;
            nmi_pend_o <= (nmi_pend_o & ~ack_nmi) | nmi_rise;
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic [NUM_IRQ-1:0]             cand,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
    output pick_t                          pick_o
);

    // ascending scan with strict compare keeps the lower index on ties
    always_comb begin
        pick_o = '0;
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (cand[k] && (!pick_o.found || prio[k] < pick_o.prio)) begin
                pick_o.found = 1'b1;
                pick_o.line  = NUM_W'(k);
                pick_o.prio  = prio[k];
            end
        end
    end

endmodule

// File: rtl/irqc_stack.sv
module irqc_stack
    import irqc_pkg::*;
#(
    parameter int SLOTS = 5,
    parameter int SP_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  frame_t            push_frame,
    input  logic              pop,
    output logic [SP_W-1:0]   depth_o,
    output frame_t            top_o,
    output logic [RANK_W-1:0] cur_rank_o
);

    frame_t slot [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_o <= '0;
            for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
        end else if (pop) begin
            if (depth_o != '0) depth_o <= depth_o - SP_W'(1);
        end else if (push && depth_o < SP_W'(SLOTS)) begin
            for (int i = 0; i < SLOTS; i++)
                if (depth_o == SP_W'(i)) slot[i] <= push_frame;
            depth_o <= depth_o + SP_W'(1);
        end
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < SLOTS; i++)
            if (depth_o == SP_W'(i + 1)) top_o = slot[i];
    end

    assign cur_rank_o = (depth_o == '0) ? THREAD_RANK : top_o.rank;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          NUM_IRQ     = 16,
    parameter int          STACK_DEPTH = 4,
    parameter logic [31:0] VEC_BASE    = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               nmi,
    input  logic               wr_en,
    input  logic [9:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               ack,
    input  logic               done,
    output logic               req_valid,
    output logic [7:0]         req_num,
    output logic [31:0]        req_vec
);

    // one slot beyond the maskable limit is held back for the non-maskable level
    localparam int SLOTS = STACK_DEPTH + 1;
    localparam int SP_W  = $clog2(SLOTS + 1);

    logic [NUM_IRQ-1:0]             en;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
    logic [PRIO_W-1:0]              thr;
    logic                           gmask;
    logic [NUM_IRQ-1:0]             pend, active, cand;
    logic [NUM_IRQ-1:0]             ack_hot, done_hot;
    logic                           nmi_pend;
    pick_t                          pick;
    logic [SP_W-1:0]                depth;
    frame_t                         top_frame, push_frame;
    logic [RANK_W-1:0]              cur_rank, win_rank;
    logic                           thr_block, room, mask_take, nmi_take;
    logic                           ack_fire, pop;

    irqc_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en_o(en), .prio_o(prio), .thr_o(thr), .gmask_o(gmask)
    );

    irqc_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk(clk), .rst(rst), .lines(irq_lines), .nmi_in(nmi),
        .ack_hot(ack_hot), .ack_nmi(ack_fire && nmi_take), .done_hot(done_hot),
        .pend_o(pend), .active_o(active), .nmi_pend_o(nmi_pend)
    );

    assign cand = pend & en & ~active;

    irqc_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .cand(cand), .prio(prio), .pick_o(pick)
    );

    irqc_stack #(.SLOTS(SLOTS), .SP_W(SP_W)) u_stack (
        .clk(clk), .rst(rst), .push(ack_fire), .push_frame(push_frame), .pop(pop),
        .depth_o(depth), .top_o(top_frame), .cur_rank_o(cur_rank)
    );

    assign win_rank  = prio_rank(pick.prio);
    assign thr_block = (thr != '0) && (pick.prio >= thr);
    assign room      = depth < SP_W'(STACK_DEPTH);
    assign mask_take = pick.found && !gmask && !thr_block && room && (win_rank < cur_rank);
    assign nmi_take  = nmi_pend && (cur_rank != NMI_RANK);

    assign req_valid = nmi_take || mask_take;
    assign req_num   = nmi_take ? NMI_NUM : (EXT_BASE + pick.line);
    assign req_vec   = vec_addr(VEC_BASE, req_num);

    assign pop      = done;
    assign ack_fire = ack && req_valid && !done;

    always_comb begin
        push_frame.rank   = nmi_take ? NMI_RANK : win_rank;
        push_frame.num    = req_num;
        push_frame.is_nmi = nmi_take;
    end

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
        assign ack_hot[k]  = ack_fire && !nmi_take && (pick.line == NUM_W'(k));
        assign done_hot[k] = pop && (depth != '0) && !top_frame.is_nmi &&
                             (top_frame.num == EXT_BASE + NUM_W'(k));
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int STACK_DEPTH = 4,
    parameter int SP_W        = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic              done,
    input logic              req_valid,
    input logic [7:0]        req_num,
    input logic              gmask,
    input logic              nmi_pend,
    input logic [SP_W-1:0]   depth,
    input logic [RANK_W-1:0] cur_rank,
    input logic [RANK_W-1:0] win_rank
);

    AST_GMASK_ONLY_NMI: assert property (@(posedge clk) disable iff (rst)
        (gmask && req_valid) |-> (req_num == NMI_NUM)); // R6

    AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && cur_rank != NMI_RANK) |-> (req_valid && req_num == NMI_NUM)); // R7

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_num != NMI_NUM) |-> (win_rank < cur_rank)); // R4

    AST_NEST_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_num != NMI_NUM) |-> (depth < SP_W'(STACK_DEPTH))); // R10

    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (rst)
        (ack && req_valid && !done) |=> (depth == $past(depth) + SP_W'(1))); // R8

    AST_DONE_POP: assert property (@(posedge clk) disable iff (rst)
        (done && depth != '0) |=> (depth == $past(depth) - SP_W'(1))); // R8

    AST_THREAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (depth == '0) |-> (cur_rank == THREAD_RANK)); // R8

endmodule

bind irqc_top irqc_chk #(.STACK_DEPTH(STACK_DEPTH), .SP_W(SP_W)) u_chk (
    .clk(clk), .rst(rst), .ack(ack), .done(done), .req_valid(req_valid),
    .req_num(req_num), .gmask(gmask), .nmi_pend(nmi_pend), .depth(depth),
    .cur_rank(cur_rank), .win_rank(win_rank)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;

    localparam int          NIRQ = 16;
    localparam logic [31:0] BASE = 32'h0800_0000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NIRQ-1:0] irq = '0;
    logic            nmi = 1'b0;
    logic            wr_en = 1'b0;
    logic [9:0]      wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic            ack = 1'b0;
    logic            done = 1'b0;
    logic            req_valid;
    logic [7:0]      req_num;
    logic [31:0]     req_vec;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irqc_top #(.NUM_IRQ(NIRQ), .STACK_DEPTH(4), .VEC_BASE(BASE)) i_irqc_top (
        .clk(clk), .rst(rst), .irq_lines(irq), .nmi(nmi), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack), .done(done),
        .req_valid(req_valid), .req_num(req_num), .req_vec(req_vec)
    );

    typedef struct packed {
        logic [15:0] lines;
        logic        vld;
        logic [7:0]  num;
    } vec_t;

    // priorities: line k gets ((k % 4) + 1) * 16
    localparam vec_t TABLE [0:6] = '{
        '{16'h0010, 1'b1, 8'd20},
        '{16'h0011, 1'b1, 8'd16},
        '{16'h00F0, 1'b1, 8'd20},
        '{16'h000E, 1'b1, 8'd17},
        '{16'h8000, 1'b1, 8'd31},
        '{16'h0A00, 1'b1, 8'd25},
        '{16'h0000, 1'b0, 8'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_req(input string tag, input logic v, input logic [7:0] n);
        check({tag, " valid"}, {31'b0, req_valid}, {31'b0, v});
        if (v) begin
            check({tag, " num"}, {24'b0, req_num}, {24'b0, n});
            check({tag, " vec R3"}, req_vec, BASE + {22'b0, n, 2'b00});
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] sel, input int idx, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = {sel, 8'(idx)}; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic config_all();
        for (int k = 0; k < NIRQ; k++) begin
            wreg(2'b10, k, 32'(((k % 4) + 1) * 16));
            wreg(2'b01, k, 32'd1);
        end
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk); irq = m;
        @(negedge clk); irq = '0;
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi = 1'b1;
        @(negedge clk); nmi = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_done();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // table walk: R2 selection and tie-break, R3 vector
        for (int i = 0; i < 7; i++) begin
            do_reset();
            config_all();
            pulse(TABLE[i].lines);
            expect_req($sformatf("R2 table entry %0d", i), TABLE[i].vld, TABLE[i].num);
        end

        // R12 reset state, R11 disabled line latches but waits for enable
        do_reset();
        expect_req("R12 no offer after reset", 1'b0, 8'd0);
        pulse(16'h0001);
        expect_req("R11 disabled line not offered", 1'b0, 8'd0);
        wreg(2'b01, 0, 32'd1);
        expect_req("R11 enabled pending line offered", 1'b1, 8'd16);

        // R1 level hold does not re-pend
        do_reset();
        config_all();
        @(negedge clk); irq[1] = 1'b1;
        @(negedge clk);
        expect_req("R1 edge latched", 1'b1, 8'd17);
        do_ack();
        expect_req("R1 pending cleared by ack", 1'b0, 8'd0);
        do_done();
        expect_req("R1 held line not re-pended", 1'b0, 8'd0);
        @(negedge clk); irq[1] = 1'b0;
        pulse(16'h0002);
        expect_req("R1 new edge re-pends", 1'b1, 8'd17);

        // R5 threshold
        do_reset();
        config_all();
        wreg(2'b00, 1, 32'd32);
        pulse(16'h0002);
        expect_req("R5 priority equal to threshold blocked", 1'b0, 8'd0);
        pulse(16'h0001);
        expect_req("R5 priority below threshold passes", 1'b1, 8'd16);
        do_ack();
        do_done();
        expect_req("R5 still blocked", 1'b0, 8'd0);
        wreg(2'b00, 1, 32'd0);
        expect_req("R5 zero threshold disables", 1'b1, 8'd17);

        // R6 global mask, R7 non-maskable input
        do_reset();
        config_all();
        wreg(2'b00, 0, 32'd1);
        pulse(16'h0001);
        expect_req("R6 global mask blocks", 1'b0, 8'd0);
        pulse_nmi();
        expect_req("R7 nmi through global mask", 1'b1, 8'd2);
        do_ack();
        expect_req("R7 nothing while nmi active", 1'b0, 8'd0);
        pulse_nmi();
        expect_req("R7 nmi not reentered", 1'b0, 8'd0);
        do_done();
        expect_req("R7 second nmi after return", 1'b1, 8'd2);
        do_ack();
        do_done();
        expect_req("R6 mask still blocks line 0", 1'b0, 8'd0);
        wreg(2'b00, 0, 32'd0);
        expect_req("R6 unmask releases line 0", 1'b1, 8'd16);

        // R4 strict compare, R8 push and pop
        do_reset();
        config_all();
        pulse(16'h0002);
        expect_req("R4 first from thread", 1'b1, 8'd17);
        do_ack();
        pulse(16'h0020);
        expect_req("R4 equal priority waits", 1'b0, 8'd0);
        pulse(16'h0001);
        expect_req("R4 more urgent preempts", 1'b1, 8'd16);
        do_ack();
        expect_req("R8 nested level running", 1'b0, 8'd0);
        do_done();
        expect_req("R8 restored to preempted priority", 1'b0, 8'd0);
        do_done();
        expect_req("R8 back at thread level", 1'b1, 8'd21);

        // R9 no self-preemption after a priority rewrite
        do_reset();
        config_all();
        pulse(16'h0004);
        expect_req("R9 line 2 offered", 1'b1, 8'd18);
        do_ack();
        wreg(2'b10, 2, 32'd8);
        pulse(16'h0004);
        expect_req("R9 active line not offered", 1'b0, 8'd0);
        do_done();
        expect_req("R9 offered after completion", 1'b1, 8'd18);

        // R10 nesting limit, R7 nmi beyond it
        do_reset();
        config_all();
        wreg(2'b10, 6, 32'd0);
        pulse(16'h0008);
        expect_req("R10 level 1", 1'b1, 8'd19);
        do_ack();
        pulse(16'h0004);
        expect_req("R10 level 2", 1'b1, 8'd18);
        do_ack();
        pulse(16'h0002);
        expect_req("R10 level 3", 1'b1, 8'd17);
        do_ack();
        pulse(16'h0001);
        expect_req("R10 level 4", 1'b1, 8'd16);
        do_ack();
        pulse(16'h0040);
        expect_req("R10 full stack blocks maskable", 1'b0, 8'd0);
        pulse_nmi();
        expect_req("R7 nmi at full stack", 1'b1, 8'd2);
        do_ack();
        do_done();
        expect_req("R10 still full after nmi return", 1'b0, 8'd0);
        do_done();
        expect_req("R10 room again", 1'b1, 8'd22);

        summary();
        $finish;
    end

endmodule